// File: doc/BRIEF.md
# Receive Address Filter and CRC Checker

This block sits behind bit-rate recovery in a packet receiver. It takes one recovered bit per `bit_valid_i` strobe, with `sop_i` marking the first bit after preamble lock. It compares the leading address bytes against the local device address and stops at the first byte that differs. When the address matches, it walks over the optional sender address, collects the payload and the two trailing check bytes, and runs a CRC-16 over the address and the payload.

Payload bytes go into a single-packet receive buffer as they arrive. They become visible to the host only once the packet ends with a correct check value, or with a bad check value when the keep-on-error option is set. A good packet raises an interrupt, whose active level is selectable. The host drains the buffer through a show-ahead read port. While a packet is still unread, a new start of packet is refused and counted as a drop.

Top module: `rx_pkt_filter`

## Requirements
- R1: Bits arrive most significant first. A packet is made of `addr_len_i` address bytes (1..5), then as many sender bytes when `sender_en_i` is 1, then `pay_len_i` payload bytes (1..36), then two CRC bytes, high byte first. Address byte k (k=0 first) must equal `own_addr_i[8*(addr_len_i-1-k) +: 8]`.
- R2: A packet whose address differs in any bit leaves `avail_o` at 0 and the interrupt inactive.
- R3: Only payload bytes reach the buffer, in arrival order. While `avail_o` is 1, `rd_data_o` shows the oldest unread byte. A cycle with `rd_en_i` high moves to the next byte, and reading the last byte drops `avail_o`.
- R4: The CRC is CCITT polynomial 0x1021, seed 0xFFFF, processed MSB first over the address and payload bytes only, not the sender bytes. When it matches the received value, the packet becomes readable and the interrupt goes active on the clock edge that takes the last CRC bit.
- R5: `irq_o` is active high when `int_pol_i`=1 and active low when `int_pol_i`=0. It returns to inactive on the edge that reads the last payload byte.
- R6: A packet with a CRC mismatch is discarded (`avail_o` stays 0). When `keep_bad_i`=1 it is kept and readable instead, but the interrupt stays inactive.
- R7: A start of packet while unread data remains is ignored. `drop_cnt_o` increments by one, and the unread data is unchanged.
- R8: A start of packet in the middle of a capture abandons the partial packet and begins a new one.
- R9: After reset, `avail_o`=0, `drop_cnt_o`=0 and the interrupt is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | A received bit is present this cycle |
| bit_i | input | 1 | Received bit value |
| sop_i | input | 1 | This bit is the first bit of a packet |
| own_addr_i | input | 40 | Local address, low `addr_len_i` bytes used |
| addr_len_i | input | 3 | Address length in bytes, 1..5 |
| sender_en_i | input | 1 | Sender address present after destination |
| pay_len_i | input | 6 | Payload length in bytes, 1..36 |
| keep_bad_i | input | 1 | Keep packets whose CRC fails |
| int_pol_i | input | 1 | Interrupt level: 1 active high, 0 active low |
| rd_en_i | input | 1 | Host consumes the byte on `rd_data_o` |
| rd_data_o | output | 8 | Oldest unread payload byte |
| avail_o | output | 1 | Unread payload present |
| irq_o | output | 1 | Good-packet interrupt |
| drop_cnt_o | output | 8 | Packets refused while data was unread, wrapping |

## Verification
A wrong byte or bit counter in the parser shifts the field boundaries. The effect shows at the ports on the very packet being received: wrong payload bytes on `rd_data_o`, or a CRC failure that leaves `avail_o` low one cycle after the last bit. A corrupted CRC register or a wrong CRC span shows up the same way, as a missing interrupt or a missing packet. A stuck buffer pointer shows as read data that repeats or is out of order, or as `avail_o` that fails to fall after the last read. The bench sweeps every address length with and without a sender field, over short and full-length payloads, so each such fault shows within one packet.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SNDR, ST_PAY, ST_CRC} rx_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/rx_pkt_crc.sv
module rx_pkt_crc
  import rx_pkt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, base;

  assign base  = init_i ? CRC_SEED : crc_q;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (en_i)   crc_q <= crc_step(base, bit_i);
    else if (init_i) crc_q <= CRC_SEED;
  end
endmodule

// File: rtl/rx_pkt_parse.sv
module rx_pkt_parse
  import rx_pkt_pkg::*;
#(
  parameter int MAX_ADDR_BYTES = 5,
  parameter int MAX_PAY        = 36,
  localparam int ADDR_W = 8 * MAX_ADDR_BYTES,
  localparam int AL_W   = $clog2(MAX_ADDR_BYTES + 1),
  localparam int PAY_W  = $clog2(MAX_PAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              sop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [AL_W-1:0]   addr_len_i,
  input  logic              sender_en_i,
  input  logic [PAY_W-1:0]  pay_len_i,
  input  logic              keep_bad_i,
  input  logic              pending_i,
  input  logic [15:0]       crc_calc_i,
  output logic              crc_init_o,
  output logic              crc_en_o,
  output logic              start_o,
  output logic              push_o,
  output logic [7:0]        push_data_o,
  output logic              commit_o,
  output logic              good_o,
  output logic              drop_o
);
  rx_state_e        state_q;
  logic [2:0]       bit_cnt_q;
  logic [PAY_W-1:0] byte_cnt_q;
  logic [7:0]       sh_q, sh_nx, own_byte;
  logic [15:0]      crc_rx_q, crc_rx_nx;
  logic             body_bit, byte_done, last_addr, last_pay, last_crc;

  assign sh_nx     = {sh_q[6:0], bit_i};
  assign crc_rx_nx = {crc_rx_q[14:0], bit_i};
  assign body_bit  = bit_valid_i && !sop_i && (state_q != ST_IDLE);
  assign byte_done = body_bit && (bit_cnt_q == 3'd7);
  assign last_addr = (byte_cnt_q + PAY_W'(1)) == PAY_W'(addr_len_i);
  assign last_pay  = (byte_cnt_q + PAY_W'(1)) == pay_len_i;
  assign last_crc  = byte_done && (state_q == ST_CRC) && (byte_cnt_q == PAY_W'(1));

  // expected address byte: most significant configured byte first
  always_comb begin
    own_byte = 8'h00;
    for (int k = 0; k < MAX_ADDR_BYTES; k++)
      if ((PAY_W'(k) + byte_cnt_q + PAY_W'(1)) == PAY_W'(addr_len_i))
        own_byte = own_addr_i[8*k +: 8];
  end

  assign start_o     = bit_valid_i && sop_i && !pending_i;
  assign drop_o      = bit_valid_i && sop_i && pending_i;
  assign crc_init_o  = start_o;
  assign crc_en_o    = start_o || (body_bit && (state_q == ST_ADDR || state_q == ST_PAY));
  assign push_o      = byte_done && (state_q == ST_PAY);
  assign push_data_o = sh_nx;
  assign good_o      = last_crc && (crc_rx_nx == crc_calc_i);
  assign commit_o    = last_crc && (good_o || keep_bad_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      sh_q       <= '0;
      crc_rx_q   <= '0;
    end else if (bit_valid_i && sop_i) begin
      state_q    <= pending_i ? ST_IDLE : ST_ADDR;
      bit_cnt_q  <= 3'd1;
      byte_cnt_q <= '0;
      sh_q       <= {7'b0, bit_i};
    end else if (body_bit) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      sh_q      <= sh_nx;
      unique case (state_q)
        ST_ADDR: if (byte_done) begin
          if (sh_nx != own_byte) state_q <= ST_IDLE;
          else if (last_addr) begin
            byte_cnt_q <= '0;
            state_q    <= sender_en_i ? ST_SNDR : ST_PAY;
          end else byte_cnt_q <= byte_cnt_q + PAY_W'(1);
        end
        ST_SNDR: if (byte_done) begin
          if (last_addr) begin
            byte_cnt_q <= '0;
            state_q    <= ST_PAY;
          end else byte_cnt_q <= byte_cnt_q + PAY_W'(1);
        end
        ST_PAY: if (byte_done) begin
          if (last_pay) begin
            byte_cnt_q <= '0;
            state_q    <= ST_CRC;
          end else byte_cnt_q <= byte_cnt_q + PAY_W'(1);
        end
        ST_CRC: begin
          crc_rx_q <= crc_rx_nx;
          if (byte_done) begin
            if (byte_cnt_q == PAY_W'(1)) state_q <= ST_IDLE;
            else byte_cnt_q <= byte_cnt_q + PAY_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int DEPTH = 36,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       commit_i,
  input  logic       good_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic       avail_o,
  output logic       irq_q_o
);
  logic [7:0]    mem [0:DEPTH-1];
  logic [AW-1:0] wr_q, cmt_q, rd_q;
  logic          irq_q;

  assign avail_o   = rd_q != cmt_q;
  assign rd_data_o = avail_o ? mem[rd_q] : 8'h00;
  assign irq_q_o   = irq_q;

  always_ff @(posedge clk_i)
    if (push_i && wr_q < AW'(DEPTH)) mem[wr_q] <= push_data_i;

  // uncommitted bytes stay hidden from the reader until commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else if (start_i) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (push_i && wr_q < AW'(DEPTH)) wr_q <= wr_q + AW'(1);
      if (commit_i) begin
        cmt_q <= wr_q;
        irq_q <= good_i;
      end
      if (rd_en_i && avail_o) begin
        rd_q <= rd_q + AW'(1);
        if (rd_q + AW'(1) == cmt_q) irq_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter #(
  parameter int MAX_ADDR_BYTES = 5,
  parameter int MAX_PAY        = 36,
  parameter int DROP_W         = 8,
  localparam int ADDR_W = 8 * MAX_ADDR_BYTES,
  localparam int AL_W   = $clog2(MAX_ADDR_BYTES + 1),
  localparam int PAY_W  = $clog2(MAX_PAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              sop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [AL_W-1:0]   addr_len_i,
  input  logic              sender_en_i,
  input  logic [PAY_W-1:0]  pay_len_i,
  input  logic              keep_bad_i,
  input  logic              int_pol_i,
  input  logic              rd_en_i,
  output logic [7:0]        rd_data_o,
  output logic              avail_o,
  output logic              irq_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic        crc_init, crc_en, start, push, commit, good, drop, irq_q;
  logic [7:0]  push_data;
  logic [15:0] crc_calc;
  logic [DROP_W-1:0] drop_q;

  rx_pkt_parse #(.MAX_ADDR_BYTES(MAX_ADDR_BYTES), .MAX_PAY(MAX_PAY)) parse_i (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i, .sop_i, .own_addr_i, .addr_len_i,
    .sender_en_i, .pay_len_i, .keep_bad_i,
    .pending_i(avail_o), .crc_calc_i(crc_calc),
    .crc_init_o(crc_init), .crc_en_o(crc_en), .start_o(start),
    .push_o(push), .push_data_o(push_data), .commit_o(commit),
    .good_o(good), .drop_o(drop)
  );

  rx_pkt_crc crc_i (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .bit_i, .crc_o(crc_calc)
  );

  rx_pkt_fifo #(.DEPTH(MAX_PAY)) fifo_i (
    .clk_i, .rst_ni, .start_i(start), .push_i(push), .push_data_i(push_data),
    .commit_i(commit), .good_i(good), .rd_en_i, .rd_data_o, .avail_o,
    .irq_q_o(irq_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   drop_q <= '0;
    else if (drop) drop_q <= drop_q + DROP_W'(1);
  end

  assign drop_cnt_o = drop_q;
  assign irq_o      = int_pol_i ? irq_q : ~irq_q;
endmodule

// File: rtl/rx_pkt_filter_chk.sv
module rx_pkt_filter_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_valid_i,
  input logic              sop_i,
  input logic              rd_en_i,
  input logic              int_pol_i,
  input logic [7:0]        rd_data_o,
  input logic              avail_o,
  input logic              irq_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  logic irq_act;
  assign irq_act = (irq_o == int_pol_i);

  p_drop_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1)));

  p_drop_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> $past(sop_i && bit_valid_i && avail_o));

  p_avail_on_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> $past(bit_valid_i));

  p_irq_has_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_act |-> avail_o);

  p_hold_unread_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !rd_en_i) |=> (avail_o && $stable(rd_data_o)));
endmodule

bind rx_pkt_filter rx_pkt_filter_chk #(.DROP_W(DROP_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_valid_i(bit_valid_i), .sop_i(sop_i),
  .rd_en_i(rd_en_i), .int_pol_i(int_pol_i), .rd_data_o(rd_data_o),
  .avail_o(avail_o), .irq_o(irq_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/rx_pkt_filter_tb.sv
module rx_pkt_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_valid = 1'b0, bit_v = 1'b0, sop = 1'b0;
  logic [39:0] own_addr = 40'hA1B2C3D4E5;
  logic [2:0]  addr_len = 3'd1;
  logic        sender_en = 1'b0, keep_bad = 1'b0, int_pol = 1'b1, rd_en = 1'b0;
  logic [5:0]  pay_len = 6'd1;
  logic [7:0]  rd_data;
  logic        avail, irq;
  logic [7:0]  drop_cnt;

  int errors = 0, checks = 0, exp_drop = 0, pkt_n = 0;
  bit done = 0;
  logic [7:0] pkt [0:63];
  logic [7:0] exp_pay [0:35];

  always #5 clk = ~clk;

  rx_pkt_filter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(bit_valid), .bit_i(bit_v), .sop_i(sop),
    .own_addr_i(own_addr), .addr_len_i(addr_len), .sender_en_i(sender_en),
    .pay_len_i(pay_len), .keep_bad_i(keep_bad), .int_pol_i(int_pol), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .avail_o(avail), .irq_o(irq), .drop_cnt_o(drop_cnt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // R1 framing, R4 CRC span: address and payload, sender excluded
  task automatic build(int l, bit snd, int plen, int seed, bit bad_crc, int bad_addr);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    pkt_n = 0;
    for (int k = 0; k < l; k++) begin
      b = own_addr[8*(l-1-k) +: 8];
      if (k == bad_addr) b = b ^ 8'h10;
      pkt[pkt_n] = b; pkt_n++;
      c = crc_upd(c, b);
    end
    if (snd)
      for (int k = 0; k < l; k++) begin
        pkt[pkt_n] = 8'(8'h5A ^ (k * 37) ^ seed); pkt_n++;
      end
    for (int i = 0; i < plen; i++) begin
      b = 8'(seed * 7 + i * 13 + l);
      exp_pay[i] = b;
      pkt[pkt_n] = b; pkt_n++;
      c = crc_upd(c, b);
    end
    if (bad_crc) c = c ^ 16'h0001;
    pkt[pkt_n] = c[15:8]; pkt_n++;
    pkt[pkt_n] = c[7:0];  pkt_n++;
  endtask

  task automatic send(int nbytes);
    for (int i = 0; i < nbytes; i++)
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk);
        bit_valid = 1'b1;
        bit_v     = pkt[i][b];
        sop       = (i == 0 && b == 7);
      end
    @(negedge clk);
    bit_valid = 1'b0;
    sop       = 1'b0;
  endtask

  task automatic cfg(int l, bit snd, int plen, bit keep, bit pol);
    @(negedge clk);
    addr_len  = 3'(l);
    sender_en = snd;
    pay_len   = 6'(plen);
    keep_bad  = keep;
    int_pol   = pol;
  endtask

  task automatic drain(string req, int plen, bit exp_irq);
    for (int i = 0; i < plen; i++) begin
      check({req, " avail"}, 32'(avail), 1);
      check({req, " data"}, 32'(rd_data), 32'(exp_pay[i]));
      check("R5 irq before last read", 32'(irq == int_pol), 32'(exp_irq));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    check("R3 avail after last read", 32'(avail), 0);
    check("R5 irq inactive after read", 32'(irq), 32'(!int_pol));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 avail at reset", 32'(avail), 0);
    check("R9 irq at reset", 32'(irq), 0);
    check("R9 drop at reset", 32'(drop_cnt), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5: sweep address length, sender field, payload length, polarity
    for (int l = 1; l <= 5; l++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 3; p++) begin
          int plen;
          plen = (p == 0) ? 1 : (p == 1) ? 5 : 36;
          cfg(l, s[0], plen, 1'b0, l[0]);
          build(l, s[0], plen, l * 11 + s * 3 + p, 1'b0, -1);
          send(pkt_n);
          check("R4 irq active after good CRC", 32'(irq), 32'(l[0]));
          drain("R1 R3 payload", plen, 1'b1);
        end

    // R2: mismatch in first and last address byte
    for (int l = 1; l <= 5; l++)
      for (int w = 0; w < 2; w++) begin
        cfg(l, 1'b0, 4, 1'b1, 1'b1);
        build(l, 1'b0, 4, 99, 1'b0, (w == 0) ? 0 : l - 1);
        send(pkt_n);
        check("R2 mismatch avail", 32'(avail), 0);
        check("R2 mismatch irq", 32'(irq), 0);
      end

    // R6: bad CRC dropped, then kept with override
    cfg(3, 1'b1, 8, 1'b0, 1'b0);
    build(3, 1'b1, 8, 5, 1'b1, -1);
    send(pkt_n);
    check("R6 bad CRC discarded", 32'(avail), 0);
    check("R6 bad CRC no irq", 32'(irq), 1);
    cfg(3, 1'b1, 8, 1'b1, 1'b0);
    send(pkt_n);
    check("R6 bad CRC kept irq inactive", 32'(irq), 1);
    drain("R6 kept payload", 8, 1'b0);

    // R7: second packet while first unread
    cfg(2, 1'b0, 6, 1'b0, 1'b1);
    build(2, 1'b0, 6, 21, 1'b0, -1);
    send(pkt_n);
    build(2, 1'b0, 6, 40, 1'b0, -1);
    send(pkt_n);
    exp_drop++;
    check("R7 drop counter", 32'(drop_cnt), 32'(exp_drop));
    check("R7 irq kept", 32'(irq), 1);
    build(2, 1'b0, 6, 21, 1'b0, -1);
    drain("R7 original payload", 6, 1'b1);
    check("R7 drop counter stable", 32'(drop_cnt), 32'(exp_drop));

    // R8: partial packet cut by a new start of packet
    cfg(2, 1'b0, 6, 1'b0, 1'b1);
    build(2, 1'b0, 6, 77, 1'b0, -1);
    send(5);
    check("R8 partial not visible", 32'(avail), 0);
    build(2, 1'b0, 6, 88, 1'b0, -1);
    send(pkt_n);
    check("R8 restart irq", 32'(irq), 1);
    drain("R8 restarted payload", 6, 1'b1);
    check("R8 no drop on restart", 32'(drop_cnt), 32'(exp_drop));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule